// File: doc/BRIEF.md
# AC'97 Codec Register Access Controller

This block is the command and status path of an AC'97 link controller. Software reaches the registers of an external codec through a small CPU-side register file. To issue a codec register write, software first loads the value into the command-data register and then loads the register index into the command-address register. The second of these writes queues the command. To issue a read, software sets the read-request bit in the command-address word. The queued command words are then driven in the two command slots of the next link frame.

The link itself is abstracted. A one-cycle `frameStart` strobe marks each frame boundary, and slot words are exchanged in parallel together with per-slot tag bits. Serial shifting, audio slots and FIFOs belong to neighbouring blocks. When a frame brings back tagged status slots, the returned words are captured and exposed through two response registers. Per-slot busy and valid flags let software poll for progress. The block also drives the codec's active-low reset line and a codec-select field.

Top module: `ac97CmdTop`

Register map on `regAddr`:
- 0: control. Bit 0 enables command-address transmit, bit 1 enables command-data transmit, bit 2 enables status-address receive, bit 3 enables status-data receive, and bits 5:4 hold the codec select.
- 1: command address.
- 2: command data.
- 3: status address.
- 4: status data.
- 5: flags. Bit 0 is address busy, bit 1 is data busy, bit 2 is address valid, bit 3 is data valid.
- 6: codec reset.
- Any other address reads as zero.

## Requirements
- R1: After `rstN` is low, both tags and words are 0, all flags (register 5) are 0, `codecSel` is 0 and `codecResetN` is 0.
- R2: A write to register 2 stores bits 19:4 as the 16-bit value and sets data busy (flag bit 1). The value is not sent in a frame until an address command goes out.
- R3: A write to register 1 stores bit 19 (read request) and bits 18:12 (index). At the next `frameStart` with transmit bit 0 set, `txTag1` becomes 1 and `txWord1` carries those bits in the same positions with the rest zero. In the same frame, `txTag2`/`txWord2` carry the value at bits 19:4 if data busy is set and control bit 1 is set.
- R4: Each busy flag stays set from its register write until the frame that sends that slot. While the slot's transmit enable is clear, the command stays queued and is not sent.
- R5: Tags and words change only on a `frameStart` cycle. A frame with nothing to send drives both tags to 0 and both words to 0.
- R6: On `frameStart`, a tagged `rxWord1`/`rxWord2` is captured into register 3/4 and sets its valid flag, but only when the matching receive enable (control bit 2/3) is set. Otherwise it is ignored.
- R7: Reading register 3 (4) clears address (data) valid. A capture in the same cycle wins, and the flag stays set.
- R8: A status address whose index differs from the one requested is still captured and returned unchanged; no comparison is made.
- R9: Control bits 5:4 drive `codecSel`. Changing them leaves a queued command and its busy flag intact.
- R10: `codecResetN` follows bit 0 of the last write to register 6. Writing 0 asserts the codec reset, and writing 1 releases it.
- R11: A write to register 1 in a `frameStart` cycle takes effect after that frame. The frame sends the previously queued word, if any, and the new word goes in the following frame with busy still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (clears response valid) |
| regAddr | input | 3 | Register address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` (combinational) |
| frameStart | input | 1 | One-cycle frame boundary strobe |
| txTag1 | output | 1 | Command-address slot is valid in the current frame |
| txWord1 | output | 20 | Command-address slot word |
| txTag2 | output | 1 | Command-data slot is valid in the current frame |
| txWord2 | output | 20 | Command-data slot word |
| rxTag1 | input | 1 | Status-address slot is valid in the incoming frame |
| rxWord1 | input | 20 | Status-address slot word |
| rxTag2 | input | 1 | Status-data slot is valid in the incoming frame |
| rxWord2 | input | 20 | Status-data slot word |
| codecSel | output | 2 | Codec select |
| codecResetN | output | 1 | Codec reset, active low |

## Verification
The bench targets the orderings that are easy to get wrong:
- A data word loaded without an address command must sit idle. A design that launched it on its own would emit a stray data tag.
- A command whose transmit enable is off must keep busy asserted across frames. A design that cleared busy anyway would lose the command silently.
- A register-1 write landing on a frame strobe must neither be dropped nor sent early.
- A response read coinciding with a fresh capture must leave valid set. A design that let the read win would hide a new codec reply.
- Mismatched echoed indices must be presented as received, and disabled receive slots must leave the stored word untouched.

// File: rtl/ac97_cmd_pkg.sv
package ac97_cmd_pkg;
  localparam int REG_W    = 32;
  localparam int ADDR_W   = 3;
  localparam int SLOT_W   = 20;
  localparam int IDX_W    = 7;
  localparam int IDX_LSB  = 12;
  localparam int RD_BIT   = IDX_LSB + IDX_W;
  localparam int CMD_W    = IDX_W + 1;
  localparam int VAL_W    = 16;
  localparam int VAL_LSB  = 4;
  localparam int SEL_W    = 2;
  localparam int FLAG_W   = 4;
  localparam int CTL_TX1  = 0;
  localparam int CTL_TX2  = 1;
  localparam int CTL_RX1  = 2;
  localparam int CTL_RX2  = 3;
  localparam int CTL_SEL  = 4;
  localparam int CTRL_W   = CTL_SEL + SEL_W;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMD1 = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMD2 = 3'd2;
  localparam logic [ADDR_W-1:0] A_RSP1 = 3'd3;
  localparam logic [ADDR_W-1:0] A_RSP2 = 3'd4;
  localparam logic [ADDR_W-1:0] A_FLAG = 3'd5;
  localparam logic [ADDR_W-1:0] A_RST  = 3'd6;

  typedef struct packed {
    logic ldCtrl;
    logic ldCmd1;
    logic ldCmd2;
    logic ldRst;
    logic send1;
    logic send2;
    logic cap1;
    logic cap2;
  } ac97Strobes_t;
endpackage

// File: rtl/ac97CmdCtrl.sv
module ac97CmdCtrl
  import ac97_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              frameStart,
  input  logic              rxTag1,
  input  logic              rxTag2,
  input  logic              tx1En,
  input  logic              tx2En,
  input  logic              rx1En,
  input  logic              rx2En,
  output ac97Strobes_t      strb,
  output logic [FLAG_W-1:0] flags
);
  logic tx1Busy, tx2Busy, rx1Valid, rx2Valid;
  logic rdRsp1, rdRsp2;

  assign rdRsp1 = regRdEn && (regAddr == A_RSP1);
  assign rdRsp2 = regRdEn && (regAddr == A_RSP2);

  always_comb begin
    strb        = '0;
    strb.ldCtrl = regWrEn && (regAddr == A_CTRL);
    strb.ldCmd1 = regWrEn && (regAddr == A_CMD1);
    strb.ldCmd2 = regWrEn && (regAddr == A_CMD2);
    strb.ldRst  = regWrEn && (regAddr == A_RST);
    strb.send1  = frameStart && tx1Busy && tx1En;
    strb.send2  = strb.send1 && tx2Busy && tx2En;
    strb.cap1   = frameStart && rxTag1 && rx1En;
    strb.cap2   = frameStart && rxTag2 && rx2En;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tx1Busy  <= 1'b0;
      tx2Busy  <= 1'b0;
      rx1Valid <= 1'b0;
      rx2Valid <= 1'b0;
    end else begin
      if (strb.ldCmd1)     tx1Busy <= 1'b1;
      else if (strb.send1) tx1Busy <= 1'b0;
      if (strb.ldCmd2)     tx2Busy <= 1'b1;
      else if (strb.send2) tx2Busy <= 1'b0;
      if (strb.cap1)       rx1Valid <= 1'b1;
      else if (rdRsp1)     rx1Valid <= 1'b0;
      if (strb.cap2)       rx2Valid <= 1'b1;
      else if (rdRsp2)     rx2Valid <= 1'b0;
    end
  end

  assign flags = {rx2Valid, rx1Valid, tx2Busy, tx1Busy};

  assert_busy1_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    tx1Busy && !frameStart |=> tx1Busy);
  assert_busy2_holds_R2: assert property (@(posedge clk) disable iff (!rstN)
    tx2Busy && !frameStart |=> tx2Busy);
  assert_valid_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    rdRsp1 && !frameStart |=> !rx1Valid);
  assert_valid_sticks_R7: assert property (@(posedge clk) disable iff (!rstN)
    rx1Valid && !regRdEn |=> rx1Valid);
endmodule

// File: rtl/ac97CmdData.sv
module ac97CmdData
  import ac97_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ac97Strobes_t      strb,
  input  logic              frameStart,
  input  logic [REG_W-1:0]  regWrData,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [FLAG_W-1:0] flags,
  input  logic [SLOT_W-1:0] rxWord1,
  input  logic [SLOT_W-1:0] rxWord2,
  output logic [REG_W-1:0]  regRdData,
  output logic              txTag1,
  output logic [SLOT_W-1:0] txWord1,
  output logic              txTag2,
  output logic [SLOT_W-1:0] txWord2,
  output logic              tx1En,
  output logic              tx2En,
  output logic              rx1En,
  output logic              rx2En,
  output logic [SEL_W-1:0]  codecSel,
  output logic              codecResetN
);
  logic [CTRL_W-1:0] ctrlReg;
  logic [CMD_W-1:0]  cmd1;
  logic [VAL_W-1:0]  cmd2;
  logic [SLOT_W-1:0] rsp1, rsp2, cmdWord1, cmdWord2;
  logic              rstRel;

  always_comb begin
    cmdWord1 = '0;
    cmdWord1[IDX_LSB +: CMD_W] = cmd1;
    cmdWord2 = '0;
    cmdWord2[VAL_LSB +: VAL_W] = cmd2;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      cmd1    <= '0;
      cmd2    <= '0;
      rsp1    <= '0;
      rsp2    <= '0;
      rstRel  <= 1'b0;
      txTag1  <= 1'b0;
      txTag2  <= 1'b0;
      txWord1 <= '0;
      txWord2 <= '0;
    end else begin
      if (strb.ldCtrl) ctrlReg <= regWrData[CTRL_W-1:0];
      if (strb.ldCmd1) cmd1    <= regWrData[IDX_LSB +: CMD_W];
      if (strb.ldCmd2) cmd2    <= regWrData[VAL_LSB +: VAL_W];
      if (strb.ldRst)  rstRel  <= regWrData[0];
      if (frameStart) begin
        txTag1  <= strb.send1;
        txTag2  <= strb.send2;
        txWord1 <= strb.send1 ? cmdWord1 : '0;
        txWord2 <= strb.send2 ? cmdWord2 : '0;
      end
      if (strb.cap1) rsp1 <= rxWord1;
      if (strb.cap2) rsp2 <= rxWord2;
    end
  end

  assign tx1En       = ctrlReg[CTL_TX1];
  assign tx2En       = ctrlReg[CTL_TX2];
  assign rx1En       = ctrlReg[CTL_RX1];
  assign rx2En       = ctrlReg[CTL_RX2];
  assign codecSel    = ctrlReg[CTL_SEL +: SEL_W];
  assign codecResetN = rstRel;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      A_CTRL:  regRdData[CTRL_W-1:0] = ctrlReg;
      A_CMD1:  regRdData[SLOT_W-1:0] = cmdWord1;
      A_CMD2:  regRdData[SLOT_W-1:0] = cmdWord2;
      A_RSP1:  regRdData[SLOT_W-1:0] = rsp1;
      A_RSP2:  regRdData[SLOT_W-1:0] = rsp2;
      A_FLAG:  regRdData[FLAG_W-1:0] = flags;
      A_RST:   regRdData[0]          = rstRel;
      default: regRdData = '0;
    endcase
  end

  assert_tag_pair_R3: assert property (@(posedge clk) disable iff (!rstN)
    txTag2 |-> txTag1);
  assert_no_send_disabled_R4: assert property (@(posedge clk) disable iff (!rstN)
    frameStart && !ctrlReg[CTL_TX1] |=> !txTag1);
  assert_tags_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(txTag1) && $stable(txTag2) && $stable(txWord1));
endmodule

// File: rtl/ac97CmdTop.sv
module ac97CmdTop
  import ac97_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              frameStart,
  output logic              txTag1,
  output logic [SLOT_W-1:0] txWord1,
  output logic              txTag2,
  output logic [SLOT_W-1:0] txWord2,
  input  logic              rxTag1,
  input  logic [SLOT_W-1:0] rxWord1,
  input  logic              rxTag2,
  input  logic [SLOT_W-1:0] rxWord2,
  output logic [SEL_W-1:0]  codecSel,
  output logic              codecResetN
);
  ac97Strobes_t      strb;
  logic [FLAG_W-1:0] flags;
  logic              tx1En, tx2En, rx1En, rx2En;

  ac97CmdCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .frameStart(frameStart), .rxTag1(rxTag1),
    .rxTag2(rxTag2), .tx1En(tx1En), .tx2En(tx2En), .rx1En(rx1En),
    .rx2En(rx2En), .strb(strb), .flags(flags)
  );

  ac97CmdData u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .frameStart(frameStart),
    .regWrData(regWrData), .regAddr(regAddr), .flags(flags),
    .rxWord1(rxWord1), .rxWord2(rxWord2), .regRdData(regRdData),
    .txTag1(txTag1), .txWord1(txWord1), .txTag2(txTag2), .txWord2(txWord2),
    .tx1En(tx1En), .tx2En(tx2En), .rx1En(rx1En), .rx2En(rx2En),
    .codecSel(codecSel), .codecResetN(codecResetN)
  );
endmodule

// File: tb/ac97CmdTop_tb.sv
module ac97CmdTop_tb;
  logic        clk = 1'b0;
  logic        rstN, regWrEn, regRdEn, frameStart, rxTag1, rxTag2;
  logic [2:0]  regAddr;
  logic [31:0] regWrData, regRdData;
  logic        txTag1, txTag2, codecResetN;
  logic [19:0] txWord1, txWord2, rxWord1, rxWord2;
  logic [1:0]  codecSel;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // reference model state
  logic [5:0]  mCtrl;
  logic [7:0]  mCmd1;
  logic [15:0] mCmd2;
  logic        mB1, mB2, mV1, mV2, mRst, mTg1, mTg2;
  logic [19:0] mRx1, mRx2, mTw1, mTw2;

  always #2 clk = ~clk;

  ac97CmdTop u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .frameStart(frameStart), .txTag1(txTag1), .txWord1(txWord1),
    .txTag2(txTag2), .txWord2(txWord2), .rxTag1(rxTag1), .rxWord1(rxWord1),
    .rxTag2(rxTag2), .rxWord2(rxWord2), .codecSel(codecSel),
    .codecResetN(codecResetN)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mRead(input logic [2:0] a);
    case (a)
      3'd0: return {26'd0, mCtrl};
      3'd1: return {12'd0, mCmd1, 12'd0};
      3'd2: return {12'd0, mCmd2, 4'd0};
      3'd3: return {12'd0, mRx1};
      3'd4: return {12'd0, mRx2};
      3'd5: return {28'd0, mV2, mV1, mB2, mB1};
      3'd6: return {31'd0, mRst};
      default: return 32'd0;
    endcase
  endfunction

  task automatic modelReset();
    mCtrl = 0; mCmd1 = 0; mCmd2 = 0; mB1 = 0; mB2 = 0; mV1 = 0; mV2 = 0;
    mRst = 0; mTg1 = 0; mTg2 = 0; mRx1 = 0; mRx2 = 0; mTw1 = 0; mTw2 = 0;
  endtask

  task automatic modelTick();
    bit s1, s2, c1, c2;
    s1 = frameStart && mB1 && mCtrl[0];
    s2 = s1 && mB2 && mCtrl[1];
    c1 = frameStart && rxTag1 && mCtrl[2];
    c2 = frameStart && rxTag2 && mCtrl[3];
    if (frameStart) begin
      mTg1 = s1; mTw1 = s1 ? {mCmd1, 12'h000} : 20'h0;
      mTg2 = s2; mTw2 = s2 ? {mCmd2, 4'h0} : 20'h0;
    end
    if (s1) mB1 = 0;
    if (s2) mB2 = 0;
    if (c1) begin mRx1 = rxWord1; mV1 = 1; end
    else if (regRdEn && regAddr == 3'd3) mV1 = 0;
    if (c2) begin mRx2 = rxWord2; mV2 = 1; end
    else if (regRdEn && regAddr == 3'd4) mV2 = 0;
    if (regWrEn) begin
      case (regAddr)
        3'd0: mCtrl = regWrData[5:0];
        3'd1: begin mCmd1 = regWrData[19:12]; mB1 = 1; end
        3'd2: begin mCmd2 = regWrData[19:4]; mB2 = 1; end
        3'd6: mRst = regWrData[0];
        default: ;
      endcase
    end
  endtask

  // compare the whole port state with the model, then advance one clock
  task automatic step(input string req);
    #1;
    chk(req, "txTag1", {31'd0, txTag1}, {31'd0, mTg1});
    chk(req, "txTag2", {31'd0, txTag2}, {31'd0, mTg2});
    chk(req, "txWord1", {12'd0, txWord1}, {12'd0, mTw1});
    chk(req, "txWord2", {12'd0, txWord2}, {12'd0, mTw2});
    chk(req, "codecSel", {30'd0, codecSel}, {30'd0, mCtrl[5:4]});
    chk(req, "codecResetN", {31'd0, codecResetN}, {31'd0, mRst});
    chk(req, "regRdData", regRdData, mRead(regAddr));
    @(posedge clk);
    modelTick();
    @(negedge clk);
    regWrEn = 0; regRdEn = 0; frameStart = 0; rxTag1 = 0; rxTag2 = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input string req);
    regWrEn = 1; regAddr = a; regWrData = d;
    step(req);
  endtask

  task automatic rdChk(input logic [2:0] a, input logic [31:0] exp, input string req);
    regRdEn = 1; regAddr = a;
    #1 chk(req, "read", regRdData, exp);
    step(req);
  endtask

  task automatic frame(input logic t1, input logic [19:0] w1,
                       input logic t2, input logic [19:0] w2, input string req);
    frameStart = 1; rxTag1 = t1; rxWord1 = w1; rxTag2 = t2; rxWord2 = w2;
    step(req);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 0; regWrEn = 0; regRdEn = 0; frameStart = 0; rxTag1 = 0; rxTag2 = 0;
    regAddr = 0; regWrData = 0; rxWord1 = 0; rxWord2 = 0;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    chk("R1", "txTag1", {31'd0, txTag1}, 0);
    chk("R1", "txWord1", {12'd0, txWord1}, 0);
    chk("R1", "codecResetN", {31'd0, codecResetN}, 0);
    chk("R1", "codecSel", {30'd0, codecSel}, 0);
    rdChk(3'd5, 32'h0, "R1");
    // R9 control enables and select
    wr(3'd0, 32'h1F, "R9");
    chk("R9", "codecSel", {30'd0, codecSel}, 1);
    // R2 data alone stays idle
    wr(3'd2, 32'h12340, "R2");
    rdChk(3'd5, 32'h2, "R2");
    frame(0, 0, 0, 0, "R2");
    chk("R2", "txTag2", {31'd0, txTag2}, 0);
    rdChk(3'd5, 32'h2, "R2");
    // R3 write command goes with data
    wr(3'd1, 32'h02000, "R3");
    rdChk(3'd5, 32'h3, "R4");
    frame(0, 0, 0, 0, "R3");
    chk("R3", "txTag1", {31'd0, txTag1}, 1);
    chk("R3", "txWord1", {12'd0, txWord1}, 32'h02000);
    chk("R3", "txTag2", {31'd0, txTag2}, 1);
    chk("R3", "txWord2", {12'd0, txWord2}, 32'h12340);
    rdChk(3'd5, 32'h0, "R4");
    // R5 empty frame
    frame(0, 0, 0, 0, "R5");
    chk("R5", "txTag1", {31'd0, txTag1}, 0);
    chk("R5", "txWord1", {12'd0, txWord1}, 0);
    // R3 read request bit
    wr(3'd1, 32'hFC000, "R3");
    frame(0, 0, 0, 0, "R3");
    chk("R3", "txWord1", {12'd0, txWord1}, 32'hFC000);
    chk("R3", "txTag2", {31'd0, txTag2}, 0);
    // R4 held while disabled, R9 select change keeps it
    wr(3'd0, 32'h1E, "R4");
    wr(3'd1, 32'h05000, "R4");
    frame(0, 0, 0, 0, "R4");
    frame(0, 0, 0, 0, "R4");
    chk("R4", "txTag1", {31'd0, txTag1}, 0);
    rdChk(3'd5, 32'h1, "R4");
    wr(3'd0, 32'h2F, "R9");
    chk("R9", "codecSel", {30'd0, codecSel}, 2);
    rdChk(3'd5, 32'h1, "R9");
    frame(0, 0, 0, 0, "R9");
    chk("R9", "txWord1", {12'd0, txWord1}, 32'h05000);
    // R6 capture, R7 read clears
    frame(1, 20'h05000, 1, 20'h0ABC0, "R6");
    rdChk(3'd5, 32'hC, "R6");
    rdChk(3'd3, 32'h05000, "R6");
    rdChk(3'd5, 32'h8, "R7");
    rdChk(3'd4, 32'h0ABC0, "R6");
    rdChk(3'd5, 32'h0, "R7");
    // R8 mismatched index presented
    frame(1, 20'h33000, 1, 20'h55550, "R8");
    rdChk(3'd3, 32'h33000, "R8");
    rdChk(3'd4, 32'h55550, "R8");
    // R6 receive disabled ignores slots
    wr(3'd0, 32'h23, "R6");
    frame(1, 20'h11110, 1, 20'h22220, "R6");
    rdChk(3'd5, 32'h0, "R6");
    rdChk(3'd3, 32'h33000, "R6");
    // R7 capture wins over read
    wr(3'd0, 32'h2F, "R7");
    frame(1, 20'h44000, 1, 20'h00001, "R7");
    regRdEn = 1; regAddr = 3'd3;
    frame(1, 20'h66000, 0, 0, "R7");
    rdChk(3'd5, 32'hC, "R7");
    rdChk(3'd3, 32'h66000, "R7");
    rdChk(3'd4, 32'h00001, "R7");
    rdChk(3'd5, 32'h0, "R7");
    // R11 write during frame strobe
    regWrEn = 1; regAddr = 3'd1; regWrData = 32'h07000;
    frame(0, 0, 0, 0, "R11");
    chk("R11", "txTag1", {31'd0, txTag1}, 0);
    rdChk(3'd5, 32'h1, "R11");
    frame(0, 0, 0, 0, "R11");
    chk("R11", "txWord1", {12'd0, txWord1}, 32'h07000);
    wr(3'd1, 32'h08000, "R11");
    regWrEn = 1; regAddr = 3'd1; regWrData = 32'h09000;
    frame(0, 0, 0, 0, "R11");
    chk("R11", "txWord1", {12'd0, txWord1}, 32'h08000);
    rdChk(3'd5, 32'h1, "R11");
    frame(0, 0, 0, 0, "R11");
    chk("R11", "txWord1", {12'd0, txWord1}, 32'h09000);
    // R10 codec reset line
    chk("R10", "codecResetN", {31'd0, codecResetN}, 0);
    wr(3'd6, 32'h1, "R10");
    chk("R10", "codecResetN", {31'd0, codecResetN}, 1);
    rdChk(3'd6, 32'h1, "R10");
    wr(3'd6, 32'h0, "R10");
    chk("R10", "codecResetN", {31'd0, codecResetN}, 0);
    step("R5");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule